// File: doc/BRIEF.md
# Multi-Width ALU with Condition Flags

This block is the arithmetic and logic stage of a small processor datapath. Each cycle it may accept one operation. An operation names an opcode, an operand width of 8, 16 or 32 bits, a destination value and a source value. The block returns the result one cycle later and keeps a 4-bit condition register. The rules for updating that register depend on the operation class:

- Arithmetic operations set all four flags.
- Increment and decrement keep carry and take overflow from the pattern of the original operand.
- Logic operations and moves clear overflow and keep carry.
- Compare sets the flags and writes nothing back.

Operands enter on `op_valid` together with their fields. There is no back-pressure. The block is always ready, so each cycle with `op_valid` high is one accepted operation. On the clock edge that accepts an operation, `res_valid`, `res_data`, `res_we` and `flags` update, so they are seen in the following cycle. A separate `flag_load` port overwrites the whole condition register. It is meant for operations that transform the flags directly, for example masking them with an immediate.

Top module: `alu_core`

## Requirements
- R1: The condition register holds N at bit 3, Z at bit 2, V at bit 1 and C at bit 0. Reset clears the condition register, `res_data`, `res_valid` and `res_we` to zero.
- R2: Every cycle with `op_valid` high is accepted. On the following cycle `res_valid` is 1 and carries that operation's result, with no back-pressure.
- R3: The `op_size` input selects the width: 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. `res_data` is zero above the selected width. N is the top bit at that width. Z is 1 exactly when the result is zero at that width.
- R4: Opcode 0 (add) forms dst+src. Opcode 1 (add with carry) forms dst+src+C. C becomes the carry out of the selected width.
- R5: Opcode 2 (subtract) forms dst-src. Opcode 3 (subtract with borrow) forms dst-(src+C). Opcode 5 (negate) forms 0-src. Each is computed as the destination plus the two's complement of the subtrahend, and C becomes the borrow, which is 1 when the subtrahend exceeds the destination.
- R6: For opcodes 0 to 5, V is 1 when the destination and the effective addend have the same sign bit and the result's sign bit differs from it. The effective addend is the source, the source plus C, or the negated subtrahend, each taken at the selected width.
- R7: Opcode 4 (compare) sets the flags as subtract does and leaves `res_we` at 0.
- R8: Opcodes 8 (AND), 9 (OR), 10 (XOR) and 11 (move src) set N and Z from the result, clear V, leave C unchanged and set `res_we`.
- R9: Opcode 6 (increment) forms dst+src and opcode 7 (decrement) forms dst-src. V is 1 when every destination bit below its sign bit is 1. C is unchanged.
- R10: When `flag_load` is high, the condition register takes `flag_in` at the next edge. This overrides any flag update from an operation in the same cycle, but that operation's result and `res_we` are still produced.
- R11: Opcodes 12 to 15 are reserved. They give `res_data` 0 and `res_we` 0, and they leave the flags unchanged.
- R12: In a cycle with neither `op_valid` nor `flag_load` high, `res_valid` is 0 next cycle, while `res_data` and the flags hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation selector (codes in R4 to R11) |
| op_size | input | 2 | Operand width select (R3) |
| dst_val | input | 32 | Destination operand |
| src_val | input | 32 | Source operand, or step amount for increment and decrement |
| flag_load | input | 1 | Overwrite the condition register |
| flag_in | input | 4 | Value loaded when flag_load is high |
| res_valid | output | 1 | Result of the previous cycle's operation is present |
| res_data | output | 32 | Result, zero-extended from the selected width |
| res_we | output | 1 | Result is to be written to the destination |
| flags | output | 4 | Condition register {N,Z,V,C} |

## Verification
Random operations are driven with operands chosen from several patterns:

- Zero and all-ones operands show the boundary between carry and borrow.
- The sign-bit value and the value just below it show overflow apart from plain sign changes.
- Purely random values cover the general case.

Garbage in the bits above the selected width tests that masking and zero-extension hold at every width. Chains of back-to-back operations show that add-with-carry and subtract-with-borrow consume the C produced one cycle earlier. Cycles that mix operations with flag loads and idle cycles separate an operation's flag update from a direct load and from holding the flags.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DW     = 32;
  localparam int FW     = 4;
  localparam int OPW    = 4;
  localparam int SZW    = 2;
  localparam int BASE_W = 8;
  localparam int NLANE  = 3;
  localparam int SELW   = $clog2(NLANE);

  localparam int FN = 3;
  localparam int FZ = 2;
  localparam int FV = 1;
  localparam int FC = 0;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBB = 4'd3,
    OP_CMP  = 4'd4,
    OP_NEG  = 4'd5,
    OP_INC  = 4'd6,
    OP_DEC  = 4'd7,
    OP_AND  = 4'd8,
    OP_OR   = 4'd9,
    OP_XOR  = 4'd10,
    OP_MOV  = 4'd11
  } op_e;

  typedef enum logic [1:0] {
    CL_ARITH,
    CL_STEP,
    CL_LOGIC,
    CL_NONE
  } cls_e;

  function automatic cls_e op_class(input logic [OPW-1:0] op);
    cls_e c;
    if (op <= OP_NEG)      c = CL_ARITH;
    else if (op <= OP_DEC) c = CL_STEP;
    else if (op <= OP_MOV) c = CL_LOGIC;
    else                   c = CL_NONE;
    return c;
  endfunction
endpackage

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  output logic [DW-1:0]  y
);
  always_comb begin
    unique case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      default: y = b;
    endcase
  end
endmodule

// File: rtl/alu_lane.sv
module alu_lane
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [W-1:0]   logic_y,
  input  logic           cin,
  output logic [W-1:0]   y,
  output logic           n,
  output logic           z,
  output logic           v_arith,
  output logic           v_step,
  output logic           cout
);
  logic         is_sub;
  logic         ci;
  logic [W-1:0] dw;
  logic [W-1:0] ea;
  logic [W:0]   wide;
  logic [W-1:0] arith;

  always_comb begin
    is_sub = (op == OP_SUB) || (op == OP_SUBB) || (op == OP_CMP) ||
             (op == OP_NEG) || (op == OP_DEC);
    ci     = ((op == OP_ADDC) || (op == OP_SUBB)) ? cin : 1'b0;
    dw     = (op == OP_NEG) ? '0 : a;
    if (is_sub) begin
      wide = {1'b0, dw} - {1'b0, b} - {{W{1'b0}}, ci};
      ea   = '0 - b - {{(W-1){1'b0}}, ci};
    end else begin
      wide = {1'b0, dw} + {1'b0, b} + {{W{1'b0}}, ci};
      ea   = b + {{(W-1){1'b0}}, ci};
    end
    arith   = wide[W-1:0];
    cout    = wide[W];
    v_arith = (ea[W-1] == dw[W-1]) && (arith[W-1] != ea[W-1]);
    v_step  = &a[W-2:0];
    y       = (op_class(op) == CL_LOGIC) ? logic_y : arith;
    n       = y[W-1];
    z       = (y == '0);
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [3:0]      op_code,
  input  logic [1:0]      op_size,
  input  logic [31:0]     dst_val,
  input  logic [31:0]     src_val,
  input  logic            flag_load,
  input  logic [3:0]      flag_in,
  output logic            res_valid,
  output logic [31:0]     res_data,
  output logic            res_we,
  output logic [3:0]      flags
);
  logic [DW-1:0] logic_y;
  logic [DW-1:0] lane_y  [NLANE];
  logic          lane_n  [NLANE];
  logic          lane_z  [NLANE];
  logic          lane_va [NLANE];
  logic          lane_vs [NLANE];
  logic          lane_c  [NLANE];

  logic [SELW-1:0] sel;
  cls_e            cls;
  logic [FW-1:0]   flags_q;
  logic [FW-1:0]   flags_nxt;
  logic [DW-1:0]   res_q;
  logic [DW-1:0]   res_nxt;
  logic            valid_q;
  logic            we_q;
  logic            we_nxt;

  alu_logic u_logic (
    .op (op_code),
    .a  (dst_val),
    .b  (src_val),
    .y  (logic_y)
  );

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    localparam int LW = BASE_W << i;
    logic [LW-1:0] y_w;
    alu_lane #(.W(LW)) u_lane (
      .op      (op_code),
      .a       (dst_val[LW-1:0]),
      .b       (src_val[LW-1:0]),
      .logic_y (logic_y[LW-1:0]),
      .cin     (flags_q[FC]),
      .y       (y_w),
      .n       (lane_n[i]),
      .z       (lane_z[i]),
      .v_arith (lane_va[i]),
      .v_step  (lane_vs[i]),
      .cout    (lane_c[i])
    );
    assign lane_y[i] = DW'(y_w);
  end

  always_comb begin
    sel = (int'(op_size) >= NLANE) ? SELW'(NLANE - 1) : SELW'(op_size);
    cls = op_class(op_code);
    flags_nxt = flags_q;
    res_nxt   = lane_y[sel];
    we_nxt    = 1'b1;
    unique case (cls)
      CL_ARITH: begin
        flags_nxt = {lane_n[sel], lane_z[sel], lane_va[sel], lane_c[sel]};
        we_nxt    = (op_code != OP_CMP);
      end
      CL_STEP:  flags_nxt = {lane_n[sel], lane_z[sel], lane_vs[sel], flags_q[FC]};
      CL_LOGIC: flags_nxt = {lane_n[sel], lane_z[sel], 1'b0, flags_q[FC]};
      default: begin
        res_nxt = '0;
        we_nxt  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      res_q   <= '0;
      valid_q <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      valid_q <= op_valid;
      we_q    <= op_valid && we_nxt;
      if (op_valid)
        res_q <= res_nxt;
      if (flag_load)
        flags_q <= flag_in;
      else if (op_valid)
        flags_q <= flags_nxt;
    end
  end

  assign res_valid = valid_q;
  assign res_data  = res_q;
  assign res_we    = we_q;
  assign flags     = flags_q;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk
  import alu_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [3:0]  op_code,
  input logic [1:0]  op_size,
  input logic        flag_load,
  input logic [3:0]  flag_in,
  input logic        res_valid,
  input logic [31:0] res_data,
  input logic        res_we,
  input logic [3:0]  flags
);
  AST_RESULT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !flag_load) |=> (!res_valid && $stable(flags) && $stable(res_data))); // R12

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_CMP) |=> !res_we); // R7

  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    flag_load |=> (flags == $past(flag_in))); // R10

  AST_LOGIC_V_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !flag_load && op_code >= 4'd8 && op_code <= 4'd11)
      |=> (!flags[FV] && flags[FC] == $past(flags[FC]) && res_we)); // R8

  AST_STEP_KEEP_C: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !flag_load && (op_code == OP_INC || op_code == OP_DEC))
      |=> (flags[FC] == $past(flags[FC]))); // R9

  AST_NARROW_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_size == 2'd0) |=> (res_data[31:8] == 24'd0)); // R3

  AST_Z_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !flag_load && op_code <= 4'd11) |=> (flags[FZ] == (res_data == 32'd0))); // R3

  AST_RSVD_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !flag_load && op_code >= 4'd12)
      |=> (!res_we && res_data == 32'd0 && $stable(flags))); // R11
endmodule

bind alu_core alu_core_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_code   (op_code),
  .op_size   (op_size),
  .flag_load (flag_load),
  .flag_in   (flag_in),
  .res_valid (res_valid),
  .res_data  (res_data),
  .res_we    (res_we),
  .flags     (flags)
);

// File: tb/alu_core_bench.sv
`timescale 1ns/1ps
module alu_core_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  op_code;
  logic [1:0]  op_size;
  logic [31:0] dst_val;
  logic [31:0] src_val;
  logic        flag_load;
  logic [3:0]  flag_in;
  logic        res_valid;
  logic [31:0] res_data;
  logic        res_we;
  logic [3:0]  flags;

  int checks = 0;
  int errors = 0;
  logic [3:0]  ef;
  logic [31:0] er;

  always #2.5 clk = ~clk;

  alu_core u_alu_core (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_size(op_size), .dst_val(dst_val), .src_val(src_val),
    .flag_load(flag_load), .flag_in(flag_in), .res_valid(res_valid),
    .res_data(res_data), .res_we(res_we), .flags(flags)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // returns {write_enable, flags[3:0], result[31:0]}
  function automatic logic [36:0] model(input logic [3:0] op, input logic [1:0] sz,
                                        input logic [31:0] a, input logic [31:0] b,
                                        input logic [3:0] f);
    longint unsigned mask, sb, am, bm, d, r, ea, ci, t;
    int w;
    logic we, n, z, v, c, upd;
    logic [3:0] nf;
    w = (sz == 2'd0) ? 8 : ((sz == 2'd1) ? 16 : 32);
    mask = (64'd1 << w) - 64'd1;
    sb = 64'd1 << (w - 1);
    am = {32'd0, a} & mask;
    bm = {32'd0, b} & mask;
    nf = f; we = 1'b1; r = 0; v = 1'b0; c = f[0]; upd = 1'b1; d = am;
    case (op)
      4'd0, 4'd1: begin
        ci = (op == 4'd1) ? {63'd0, f[0]} : 64'd0;
        t = am + bm + ci;
        r = t & mask;
        c = ((t >> w) & 64'd1) != 0;
        ea = (bm + ci) & mask;
        v = (((ea & sb) != 0) == ((d & sb) != 0)) && (((r & sb) != 0) != ((ea & sb) != 0));
      end
      4'd2, 4'd3, 4'd4, 4'd5: begin
        ci = (op == 4'd3) ? {63'd0, f[0]} : 64'd0;
        d = (op == 4'd5) ? 64'd0 : am;
        t = d - bm - ci;
        r = t & mask;
        c = d < (bm + ci);
        ea = (64'd0 - bm - ci) & mask;
        v = (((ea & sb) != 0) == ((d & sb) != 0)) && (((r & sb) != 0) != ((ea & sb) != 0));
        we = (op != 4'd4);
      end
      4'd6, 4'd7: begin
        r = ((op == 4'd6) ? (am + bm) : (am - bm)) & mask;
        v = (am & (sb - 64'd1)) == (sb - 64'd1);
      end
      4'd8:  r = am & bm;
      4'd9:  r = am | bm;
      4'd10: r = am ^ bm;
      4'd11: r = bm;
      default: begin we = 1'b0; upd = 1'b0; end
    endcase
    n = (r & sb) != 0;
    z = (r == 0);
    if (upd) nf = {n, z, v, c};
    return {we, nf, r[31:0]};
  endfunction

  task automatic do_op(input string req, input logic [3:0] op, input logic [1:0] sz,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic fl, input logic [3:0] fin);
    logic [36:0] m;
    m = model(op, sz, a, b, ef);
    op_valid = 1'b1; op_code = op; op_size = sz; dst_val = a; src_val = b;
    flag_load = fl; flag_in = fin;
    @(negedge clk);
    er = m[31:0];
    ef = fl ? fin : m[35:32];
    check(req, "res_valid", {31'd0, res_valid}, 32'd1);
    check(req, "res_data", res_data, er);
    check(req, "res_we", {31'd0, res_we}, {31'd0, m[36]});
    check(req, "flags", {28'd0, flags}, {28'd0, ef});
    op_valid = 1'b0; flag_load = 1'b0;
  endtask

  task automatic idle_cycle();
    op_valid = 1'b0; flag_load = 1'b0;
    @(negedge clk);
    check("R12", "res_valid idle", {31'd0, res_valid}, 32'd0);
    check("R12", "res_data idle", res_data, er);
    check("R12", "flags idle", {28'd0, flags}, {28'd0, ef});
  endtask

  task automatic load_only(input logic [3:0] fin);
    op_valid = 1'b0; flag_load = 1'b1; flag_in = fin;
    @(negedge clk);
    ef = fin;
    check("R10", "flags after load", {28'd0, flags}, {28'd0, ef});
    check("R10", "res_valid after load", {31'd0, res_valid}, 32'd0);
    flag_load = 1'b0;
  endtask

  function automatic logic [31:0] pick(input int kind);
    case (kind)
      0: return 32'd0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h0000_0080;
      3: return 32'h0000_7FFF;
      4: return 32'h8000_0000;
      5: return 32'h0000_007F;
      6: return 32'd1;
      default: return $urandom;
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4021));
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; op_size = '0;
    dst_val = '0; src_val = '0; flag_load = 1'b0; flag_in = '0;
    ef = '0; er = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1", "flags reset", {28'd0, flags}, 32'd0);
    check("R1", "res_data reset", res_data, 32'd0);
    check("R1", "res_valid reset", {31'd0, res_valid}, 32'd0);
    check("R1", "res_we reset", {31'd0, res_we}, 32'd0);

    // R4 carry out of 8 bits, zero result
    do_op("R4", 4'd0, 2'd0, 32'h0000_00FF, 32'h0000_0001, 1'b0, 4'd0);
    check("R1", "flag packing ZC", {28'd0, flags}, 32'h5);
    // R6 signed overflow at 8 bits
    do_op("R6", 4'd0, 2'd0, 32'h0000_007F, 32'h0000_0001, 1'b0, 4'd0);
    check("R6", "flag packing NV", {28'd0, flags}, 32'hA);
    // R4 add with carry, back-to-back C chain
    load_only(4'h1);
    do_op("R4", 4'd1, 2'd0, 32'h10, 32'h20, 1'b0, 4'd0);
    check("R4", "addc sum", res_data, 32'h31);
    // R5 borrow at 16 bits
    do_op("R5", 4'd2, 2'd1, 32'h0, 32'h1, 1'b0, 4'd0);
    check("R5", "sub borrow flags", {28'd0, flags}, 32'h9);
    do_op("R5", 4'd3, 2'd0, 32'h5, 32'h3, 1'b0, 4'd0);
    check("R5", "subb result", res_data, 32'h1);
    do_op("R5", 4'd5, 2'd2, 32'h1234, 32'h1, 1'b0, 4'd0);
    check("R5", "neg result", res_data, 32'hFFFF_FFFF);
    do_op("R5", 4'd5, 2'd0, 32'h0, 32'h0, 1'b0, 4'd0);
    // R7 compare
    do_op("R7", 4'd4, 2'd0, 32'h42, 32'h42, 1'b0, 4'd0);
    check("R7", "cmp no write", {31'd0, res_we}, 32'd0);
    // R9 increment overflow pattern, C kept
    load_only(4'h1);
    do_op("R9", 4'd6, 2'd1, 32'h7FFF, 32'h1, 1'b0, 4'd0);
    check("R9", "inc flags", {28'd0, flags}, 32'hB);
    do_op("R9", 4'd7, 2'd0, 32'h80, 32'h1, 1'b0, 4'd0);
    // R8 logic keeps C, clears V
    load_only(4'h3);
    do_op("R8", 4'd8, 2'd2, 32'hF0F0_0000, 32'hFFFF_0000, 1'b0, 4'd0);
    check("R8", "and flags", {28'd0, flags}, 32'h9);
    do_op("R8", 4'd11, 2'd0, 32'h0, 32'h1234_5680, 1'b0, 4'd0);
    // R3 size 3 acts as 32 bits, narrow zero extension
    do_op("R3", 4'd0, 2'd3, 32'hFFFF_FFFF, 32'h1, 1'b0, 4'd0);
    do_op("R3", 4'd9, 2'd0, 32'hAB00_0000, 32'h0000_FF00, 1'b0, 4'd0);
    // R10 load beats an operation in the same cycle
    do_op("R10", 4'd0, 2'd0, 32'h7F, 32'h1, 1'b1, 4'h6);
    // R11 reserved opcode
    do_op("R11", 4'd13, 2'd2, 32'h1, 32'h1, 1'b0, 4'd0);
    idle_cycle();

    for (int i = 0; i < 800; i++) begin
      int k;
      k = $urandom_range(0, 19);
      if (k == 0) idle_cycle();
      else if (k == 1) load_only(4'($urandom));
      else
        do_op("R2", 4'($urandom), 2'($urandom), pick($urandom_range(0, 10)),
              pick($urandom_range(0, 10)), ($urandom_range(0, 9) == 0), 4'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule